// File: doc/BRIEF.md
# Random Word Fetch Sequencer

This block is a bus master that pulls random bytes out of a random-number peripheral through a small word-wide register bus. A client issues a command on a request port. A read command brings the peripheral up and waits until it reports data ready. It recovers from seed faults along the way, drains the data in bounded chunks and streams the bytes out on a valid/ready port. At the end it releases the peripheral and reports completion with error and fatal flags.

The same command port carries acquire and release commands. Other users of the peripheral use them to keep it powered. A saturating count of holders drives the peripheral's clock-enable. The first holder runs a power-up write sequence and the last holder runs a power-down sequence. A read counts as a holder for its own duration. If the sequencer finds the peripheral switched off at the start of a chunk, it switches it on for that chunk only and switches it back off afterwards.

Top module: `rng_fetch_seq`

## Requirements
- R1: Command codes on `req_op` are 0 read, 1 acquire, 2 release and 3 no-op. `req_ready` is high only while the sequencer is idle. Each accepted command ends with `done` high for exactly one cycle, and a no-op makes no bus access.
- R2: On the first acquire (holder count 0), `rng_clk_en` rises and the control word (address 0) is written first with 0 and then with 0x24 (bit 2 enable, bit 5 clock-error-disable). On the last release, control is written with 0 and `rng_clk_en` falls after that write. Bus accesses occur only while `rng_clk_en` is high.
- R3: The holder count saturates at 2^CNT_W-1 on acquire and at 0 on release. A release at 0 makes no bus access and leaves `rng_clk_en` low.
- R4: Each chunk starts with a read of control. If bit 2 is clear, the sequencer writes 0x24 and writes 0 to control once the chunk ends. If bit 2 is set, no control write occurs during the chunk.
- R5: Bus requests hold address, direction and write data stable until `bus_ack`. Data is read only after a status read (address 1) shows bit 0 set.
- R6: A status read with bit 2 (live seed fault) or bit 6 (sticky seed fault) set starts recovery. The sequencer writes status with bit 6 at 0 and all other bits at 1, performs 12 discarded data reads (address 2), then reads status again. If bit 6 is set again, the read ends with both `done_err` and `done_fatal` set. Otherwise polling resumes.
- R7: If data-ready is not seen within TMO_CYC cycles of the chunk start, the read ends with `done_err` set and `done_fatal` clear.
- R8: Each chunk transfers min(16, remaining) bytes using ceil(bytes/4) data reads. Bytes leave each word least-significant byte first, and the unused upper bytes of a final partial word are dropped.
- R9: After any error, the read still emits exactly `req_len` bytes in total. Every byte after the failure is 0x00, and `done_err` tells the consumer to discard the whole transfer.
- R10: A read with `req_len` 0 emits no bytes and makes no data reads.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Sequencer idle, command accepted |
| req_op | input | 2 | Command code |
| req_len | input | LEN_W | Byte count for a read |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes byte |
| out_data | output | 8 | Output byte |
| done | output | 1 | Command finished, one-cycle pulse |
| done_err | output | 1 | With done: transfer invalid |
| done_fatal | output | 1 | With done: seed fault persisted |
| rng_clk_en | output | 1 | Peripheral clock enable |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 2 | Word address: 0 control, 1 status, 2 data |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ack |
| bus_ack | input | 1 | Access complete |

## Verification
The hardest conditions to reach are a seed fault that clears after recovery, a seed fault that survives it, and a peripheral that has been switched off behind the sequencer's back while another holder keeps the count above zero. The bench peripheral model has pulse inputs that raise a live seed fault, that re-arm the sticky bit on every data read, and that clear the control register between commands. It also has a programmable ready delay that can be longer than the timeout. These let each path run inside an ordinary read. An acquire issued before the forced switch-off keeps the count non-zero, so the per-chunk enable path is the one taken.

// File: rtl/rng_fetch_pkg.sv
package rng_fetch_pkg;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_ACQ  = 2'd1;
  localparam logic [1:0] OP_REL  = 2'd2;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  localparam int BIT_EN   = 2;
  localparam int BIT_CED  = 5;
  localparam int BIT_RDY  = 0;
  localparam int BIT_SLIV = 2;
  localparam int BIT_SSTK = 6;

  localparam logic [31:0] CTRL_ON  = (32'd1 << BIT_EN) | (32'd1 << BIT_CED);
  localparam logic [31:0] STAT_CLR = ~(32'd1 << BIT_SSTK);

  localparam int DISCARD_WORDS = 12;

  typedef enum logic [4:0] {
    S_IDLE, S_UP0, S_UP1, S_NEXT, S_CHK, S_EN, S_POLL, S_CLR, S_DISC,
    S_RECHK, S_RDW, S_EMIT, S_OFF, S_FILL, S_REL, S_DN0, S_DONE
  } seq_state_e;

endpackage

// File: rtl/rng_fetch_refcnt.sv
module rng_fetch_refcnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic is_zero,
  output logic is_one
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (inc && !dec && cnt_q != CMAX) begin
      cnt_n  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_n  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rng_fetch_timer.sv
module rng_fetch_timer #(
  parameter int TMO_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] t_q, t_n;
  logic          t_en;

  always_comb begin
    t_en = load || (t_q != '0);
    t_n  = load ? TW'(TMO_CYC) : t_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= '0;
    else if (t_en) t_q <= t_n;
  end

  assign expired = (t_q == '0);
endmodule

// File: rtl/rng_fetch_lane.sv
module rng_fetch_lane #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]                word,
  input  logic [$clog2(WORD_W/8)-1:0]      sel,
  input  logic                             zero,
  output logic [7:0]                       byte_o
);
  localparam int NB = WORD_W / 8;

  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_o = zero ? 8'h00 : lanes[sel];
endmodule

// File: rtl/rng_fetch_seq.sv
module rng_fetch_seq
  import rng_fetch_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int CNT_W       = 4,
  parameter int TMO_CYC     = 1000000,
  parameter int CHUNK_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [LEN_W-1:0] req_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done,
  output logic             done_err,
  output logic             done_fatal,
  output logic             rng_clk_en,
  output logic             bus_req,
  output logic             bus_we,
  output logic [1:0]       bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic [31:0]      bus_rdata,
  input  logic             bus_ack
);
  localparam int CH_W  = $clog2(CHUNK_BYTES + 1);
  localparam int DW    = $clog2(DISCARD_WORDS);
  localparam int SEL_W = 2;
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BYTES);

  seq_state_e       st_q, st_n;
  logic [1:0]       op_q, op_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic [CH_W-1:0]  chk_q, chk_n;
  logic [31:0]      wrd_q, wrd_n;
  logic [SEL_W-1:0] bi_q, bi_n;
  logic [DW-1:0]    disc_q, disc_n;
  logic             own_q, own_n, err_q, err_n, fat_q, fat_n;
  logic             cnt_inc, cnt_dec, cnt_zero, cnt_one;
  logic             tmr_load, tmr_exp, fill_sel;

  rng_fetch_refcnt #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .dec(cnt_dec),
    .is_zero(cnt_zero), .is_one(cnt_one)
  );

  rng_fetch_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_exp)
  );

  rng_fetch_lane #(.WORD_W(32)) u_lane (
    .word(wrd_q), .sel(bi_q), .zero(fill_sel), .byte_o(out_data)
  );

  always_comb begin
    st_n = st_q;  op_n = op_q;  rem_n = rem_q;  chk_n = chk_q;
    wrd_n = wrd_q; bi_n = bi_q; disc_n = disc_q;
    own_n = own_q; err_n = err_q; fat_n = fat_q;
    cnt_inc = 1'b0; cnt_dec = 1'b0; tmr_load = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = ADR_CTRL; bus_wdata = '0;
    out_valid = 1'b0; fill_sel = 1'b0; done = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        op_n = req_op; rem_n = req_len;
        own_n = 1'b0; err_n = 1'b0; fat_n = 1'b0;
        if (req_op == OP_READ || req_op == OP_ACQ) begin
          cnt_inc = 1'b1;
          if (cnt_zero)               st_n = S_UP0;
          else if (req_op == OP_READ) st_n = S_NEXT;
          else                        st_n = S_DONE;
        end else if (req_op == OP_REL) begin
          st_n = S_REL;
        end else begin
          st_n = S_DONE;
        end
      end
      S_UP0: begin
        bus_req = 1'b1; bus_we = 1'b1;
        if (bus_ack) st_n = S_UP1;
      end
      S_UP1: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CTRL_ON;
        if (bus_ack) st_n = (op_q == OP_READ) ? S_NEXT : S_DONE;
      end
      S_NEXT: begin
        if (own_q)              st_n = S_OFF;
        else if (rem_q == '0)   st_n = S_REL;
        else if (err_q)         st_n = S_FILL;
        else begin
          chk_n    = (rem_q > CHUNK_L) ? CH_W'(CHUNK_BYTES) : CH_W'(rem_q);
          tmr_load = 1'b1;
          st_n     = S_CHK;
        end
      end
      S_CHK: begin
        bus_req = 1'b1;
        if (bus_ack) st_n = bus_rdata[BIT_EN] ? S_POLL : S_EN;
      end
      S_EN: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CTRL_ON;
        if (bus_ack) begin own_n = 1'b1; st_n = S_POLL; end
      end
      S_POLL: begin
        bus_req = 1'b1; bus_addr = ADR_STAT;
        if (bus_ack) begin
          if (bus_rdata[BIT_SLIV] || bus_rdata[BIT_SSTK]) st_n = S_CLR;
          else if (bus_rdata[BIT_RDY])                    st_n = S_RDW;
          else if (tmr_exp) begin err_n = 1'b1; st_n = S_NEXT; end
        end
      end
      S_CLR: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADR_STAT; bus_wdata = STAT_CLR;
        if (bus_ack) begin disc_n = '0; st_n = S_DISC; end
      end
      S_DISC: begin
        bus_req = 1'b1; bus_addr = ADR_DATA;
        if (bus_ack) begin
          if (disc_q == DW'(DISCARD_WORDS - 1)) st_n = S_RECHK;
          else                                  disc_n = disc_q + DW'(1);
        end
      end
      S_RECHK: begin
        bus_req = 1'b1; bus_addr = ADR_STAT;
        if (bus_ack) begin
          if (bus_rdata[BIT_SSTK]) begin
            err_n = 1'b1; fat_n = 1'b1; st_n = S_NEXT;
          end else begin
            st_n = S_POLL;
          end
        end
      end
      S_RDW: begin
        bus_req = 1'b1; bus_addr = ADR_DATA;
        if (bus_ack) begin wrd_n = bus_rdata; bi_n = '0; st_n = S_EMIT; end
      end
      S_EMIT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          rem_n = rem_q - LEN_W'(1);
          chk_n = chk_q - CH_W'(1);
          bi_n  = bi_q + SEL_W'(1);
          if (chk_q == CH_W'(1))       st_n = S_NEXT;
          else if (bi_q == SEL_W'(3))  st_n = S_RDW;
        end
      end
      S_OFF: begin
        bus_req = 1'b1; bus_we = 1'b1;
        if (bus_ack) begin own_n = 1'b0; st_n = S_NEXT; end
      end
      S_FILL: begin
        out_valid = 1'b1; fill_sel = 1'b1;
        if (out_ready) begin
          rem_n = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) st_n = S_NEXT;
        end
      end
      S_REL: begin
        cnt_dec = 1'b1;
        st_n    = cnt_one ? S_DN0 : S_DONE;
      end
      S_DN0: begin
        bus_req = 1'b1; bus_we = 1'b1;
        if (bus_ack) st_n = S_DONE;
      end
      S_DONE: begin
        done = 1'b1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; op_q <= OP_READ; rem_q <= '0; chk_q <= '0;
      wrd_q <= '0; bi_q <= '0; disc_q <= '0;
      own_q <= 1'b0; err_q <= 1'b0; fat_q <= 1'b0;
    end else begin
      st_q <= st_n; op_q <= op_n; rem_q <= rem_n; chk_q <= chk_n;
      wrd_q <= wrd_n; bi_q <= bi_n; disc_q <= disc_n;
      own_q <= own_n; err_q <= err_n; fat_q <= fat_n;
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign done_err   = done & err_q;
  assign done_fatal = done & fat_q;
  assign rng_clk_en = !cnt_zero || (st_q == S_DN0);
endmodule

// File: rtl/rng_fetch_chk.sv
module rng_fetch_chk
  import rng_fetch_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        done,
  input logic        done_err,
  input logic        done_fatal,
  input logic        rng_clk_en,
  input logic        bus_req,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_req && !out_valid));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_bus_clocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> rng_clk_en);

  p_clk_off_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rng_clk_en) |-> $past(bus_ack && bus_we && bus_addr == ADR_CTRL && bus_wdata == 32'h0));

  p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  p_fatal_is_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_fatal |-> done_err);

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind rng_fetch_seq rng_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done), .done_err(done_err),
  .done_fatal(done_fatal), .rng_clk_en(rng_clk_en), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_rng_fetch_seq.sv
`timescale 1ns/1ps
module sim_rng_fetch_seq;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, out_valid, out_ready, done, done_err, done_fatal;
  logic rng_clk_en, bus_req, bus_we, bus_ack;
  logic [1:0] req_op, bus_addr;
  logic [7:0] req_len, out_data;
  logic [31:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  rng_fetch_seq #(.LEN_W(8), .CNT_W(2), .TMO_CYC(TMO), .CHUNK_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_len(req_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done), .done_err(done_err), .done_fatal(done_fatal),
    .rng_clk_en(rng_clk_en), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // peripheral model and its knobs
  logic [31:0] m_ctrl;
  logic        m_sst, m_live;
  int          m_cyc, m_words, m_dly, seed_mode;
  logic        f_off, seed_kick;

  function automatic logic [31:0] wordf(int w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = 8'(4*w + i);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_rdata <= '0; m_ctrl <= '0; m_sst <= 1'b0;
      m_live <= 1'b0; m_cyc <= 0; m_words <= 0;
    end else begin
      m_cyc   <= m_ctrl[2] ? m_cyc + 1 : 0;
      bus_ack <= bus_req && !bus_ack;
      if (f_off) m_ctrl <= '0;
      if (seed_kick) m_live <= 1'b1;
      if (bus_req && !bus_ack) begin
        if (bus_we) begin
          if (bus_addr == 2'd0) begin m_ctrl <= bus_wdata; m_cyc <= 0; end
          if (bus_addr == 2'd1 && !bus_wdata[6]) m_sst <= 1'b0;
        end else if (bus_addr == 2'd0) begin
          bus_rdata <= m_ctrl;
        end else if (bus_addr == 2'd1) begin
          bus_rdata <= '0;
          bus_rdata[0] <= m_ctrl[2] && (m_cyc >= m_dly);
          bus_rdata[2] <= m_live;
          bus_rdata[6] <= m_sst | m_live;
          if (m_live) begin m_sst <= 1'b1; m_live <= 1'b0; end
        end else begin
          bus_rdata <= wordf(m_words);
          m_words   <= m_words + 1;
          if (seed_mode == 2) m_sst <= 1'b1;
        end
      end
    end
  end

  // monitor
  logic [7:0]  gotb [0:511];
  logic [1:0]  wa [0:15];
  logic [31:0] wd [0:15];
  int ng, nw, nrd;
  logic done_seen, d_err, d_fatal;
  logic [7:0] lfsr = 8'hA5;

  always begin
    @(negedge clk);
    out_ready = lfsr[0] | lfsr[3];
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #2;
    if (rst_n) begin
      if (out_valid && out_ready && ng < 512) begin gotb[ng] = out_data; ng++; end
      if (bus_req && bus_ack && bus_we && nw < 16) begin
        wa[nw] = bus_addr; wd[nw] = bus_wdata; nw++;
      end
      if (bus_req && bus_ack && !bus_we && bus_addr == 2'd2) nrd++;
      if (done) begin done_seen = 1'b1; d_err = done_err; d_fatal = done_fatal; end
    end
  end

  int vec = 0, mis = 0, exp_w = 0, lastcyc = 0;
  logic [7:0] expb [0:511];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vec++;
    if (!ok) begin
      mis++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_len = '0;
    f_off = 1'b0; seed_kick = 1'b0; seed_mode = 0; m_dly = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; exp_w = 0;
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] op, input int len);
    ng = 0; nw = 0; nrd = 0; done_seen = 1'b0; d_err = 1'b0; d_fatal = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_len = 8'(len);
    @(negedge clk);
    req_valid = 1'b0;
    lastcyc = 1;
    while (!done_seen && lastcyc < 5000) begin
      @(negedge clk); #3; lastcyc++;
    end
    chk(done_seen, "R1 done seen", int'(done_seen), 1);
  endtask

  // expected byte stream for an error-free read starting at word w0
  function automatic int build(input int len, input int w0);
    int rem = len, w = w0, k = 0;
    while (rem > 0) begin
      int s = (rem > 16) ? 16 : rem;
      for (int j = 0; j < s; j++) begin
        expb[k] = 8'(4*(w + j/4) + (j%4)); k++;
      end
      w += (s + 3) / 4; rem -= s;
    end
    return w - w0;
  endfunction

  task automatic check_bytes(input int len, input string req);
    chk(ng == len, {req, " byte count"}, ng, len);
    for (int j = 0; j < len && j < ng; j++)
      chk(gotb[j] == expb[j], {req, " byte value"}, int'(gotb[j]), int'(expb[j]));
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    mis++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    int nwd;
    do_reset();
    // reset state (R1, R2)
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);
    chk(bus_req == 1'b0, "R2 bus idle after reset", int'(bus_req), 0);
    chk(rng_clk_en == 1'b0, "R2 clock off after reset", int'(rng_clk_en), 0);

    // length sweep 0..40 plus 255 (R2 R4 R5 R8 R10)
    for (int L = 0; L <= 41; L++) begin
      int len = (L == 41) ? 255 : L;
      m_dly = L % 7;
      nwd = build(len, exp_w);
      run(2'd0, len);
      check_bytes(len, "R8 R5");
      chk(nrd == nwd, "R8 R10 data reads", nrd, nwd);
      chk(d_err == 1'b0, "R1 no error", int'(d_err), 0);
      chk(nw == 3, "R2 R4 control write count", nw, 3);
      if (nw == 3) begin
        chk(wa[0] == 2'd0 && wd[0] == 32'h0, "R2 first write zero", int'(wd[0]), 0);
        chk(wa[1] == 2'd0 && wd[1] == 32'h24, "R2 enable write", int'(wd[1]), 36);
        chk(wa[2] == 2'd0 && wd[2] == 32'h0, "R2 power-down write", int'(wd[2]), 0);
      end
      chk(rng_clk_en == 1'b0, "R2 clock off after read", int'(rng_clk_en), 0);
      exp_w += nwd;
    end

    // seed fault cleared by recovery (R6)
    do_reset();
    seed_kick = 1'b1; @(negedge clk); seed_kick = 1'b0;
    nwd = build(8, 12);
    run(2'd0, 8);
    check_bytes(8, "R6 after recovery");
    chk(nrd == 12 + nwd, "R6 discard reads", nrd, 12 + nwd);
    chk(d_err == 1'b0, "R6 recovered no error", int'(d_err), 0);
    chk(nw == 4 && wa[2] == 2'd1 && wd[2] == 32'hFFFF_FFBF, "R6 sticky clear write", int'(wd[2]), 32'hFFFF_FFBF);

    // persistent seed fault (R6 R9)
    do_reset();
    seed_mode = 2;
    seed_kick = 1'b1; @(negedge clk); seed_kick = 1'b0;
    run(2'd0, 10);
    chk(d_err == 1'b1, "R6 error on persist", int'(d_err), 1);
    chk(d_fatal == 1'b1, "R6 fatal on persist", int'(d_fatal), 1);
    chk(nrd == 12, "R6 only discards read", nrd, 12);
    chk(ng == 10, "R9 zero-fill count", ng, 10);
    for (int j = 0; j < ng; j++) chk(gotb[j] == 8'h00, "R9 zero byte", int'(gotb[j]), 0);

    // timeout (R7 R9)
    do_reset();
    m_dly = 100000;
    run(2'd0, 5);
    chk(d_err == 1'b1, "R7 timeout error", int'(d_err), 1);
    chk(d_fatal == 1'b0, "R7 not fatal", int'(d_fatal), 0);
    chk(lastcyc >= TMO && lastcyc <= TMO + 60, "R7 timeout duration", lastcyc, TMO);
    chk(ng == 5 && nrd == 0, "R9 zero-fill count", ng, 5);
    for (int j = 0; j < ng; j++) chk(gotb[j] == 8'h00, "R9 zero byte", int'(gotb[j]), 0);

    // peripheral switched off while held (R4)
    do_reset();
    m_dly = 2;
    run(2'd1, 0);
    chk(rng_clk_en == 1'b1, "R2 clock on after acquire", int'(rng_clk_en), 1);
    f_off = 1'b1; @(negedge clk); f_off = 1'b0;
    nwd = build(20, exp_w);
    run(2'd0, 20);
    check_bytes(20, "R4 R8");
    chk(nw == 4, "R4 per-chunk enable writes", nw, 4);
    if (nw == 4) begin
      chk(wd[0] == 32'h24 && wd[1] == 32'h0 && wd[2] == 32'h24 && wd[3] == 32'h0,
          "R4 write sequence", int'(wd[1]), 0);
    end
    chk(rng_clk_en == 1'b1, "R4 clock still held", int'(rng_clk_en), 1);
    run(2'd2, 0);
    chk(nw == 1 && wd[0] == 32'h0, "R2 last release write", nw, 1);
    chk(rng_clk_en == 1'b0, "R2 clock off after release", int'(rng_clk_en), 0);

    // saturation with CNT_W=2 (R3)
    do_reset();
    for (int a = 0; a < 4; a++) begin
      run(2'd1, 0);
      chk(nw == ((a == 0) ? 2 : 0), "R3 acquire writes", nw, (a == 0) ? 2 : 0);
    end
    for (int r = 0; r < 2; r++) begin
      run(2'd2, 0);
      chk(nw == 0 && rng_clk_en == 1'b1, "R3 release above one", nw, 0);
    end
    run(2'd2, 0);
    chk(nw == 1 && rng_clk_en == 1'b0, "R3 saturated count released", nw, 1);
    run(2'd2, 0);
    chk(nw == 0 && nrd == 0 && rng_clk_en == 1'b0, "R3 release at zero", nw, 0);

    // no-op command (R1)
    run(2'd3, 9);
    chk(nw == 0 && ng == 0 && d_err == 1'b0, "R1 no-op silent", nw + ng, 0);
    chk(rng_clk_en == 1'b0, "R1 no-op clock", int'(rng_clk_en), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule